// File: doc/BRIEF.md
# Dual-Channel Window Threshold Monitor

This block checks filtered samples from two input channels against a programmable signed window. The window has a 24-bit upper limit and a 24-bit lower limit. A channel pulses its request input when a fresh sample is ready. The request is parked in a one-deep pending slot. A single shared comparator then serves the pending slots one at a time, with a fixed occupancy of `CMP_CYCLES` clocks per comparison.

Each comparison can set a per-channel "above" flag or "below" flag. These flags are sticky and are cleared by writing 1 to a clear register. The flags are ORed into a global event output, and that output drives an interrupt when enabled. Each result also fires one-clock pulses on two break lines. Two select fields choose which break lines an above result or a below result drives.

Software works through a small register port. Writes take effect on the clock edge that samples them. Reads return the addressed register one clock later.

Top module: `dual_window_monitor`

Register map (address: content):
- Address 0 is control. Bits [1:0] enable channel 0 and channel 1. Bit 8 is the interrupt enable. Bits [17:16] select the break lines for above results. Bits [25:24] select the break lines for below results.
- Address 1 is the upper limit, bits [23:0].
- Address 2 is the lower limit, bits [23:0].
- Address 3 is status and is read-only. Bit 0 is above flag ch0, bit 1 is above flag ch1, bit 2 is below flag ch0, bit 3 is below flag ch1, and bit 4 is the global event.
- Address 4 is clear. Bits [3:0] use the same positions as status, and a 1 in a bit clears that flag. This register reads as 0.

## Requirements
- R1: After synchronous reset, all flags, the break lines, the interrupt, the global event and every readable register are 0.
- R2: A sample strictly above the upper limit sets that channel's above flag (status bit 0 or 1). A sample strictly below the lower limit sets its below flag (status bit 2 or 3). A sample equal to either limit sets nothing.
- R3: Samples and limits are compared as signed two's complement. For example, 0xFFFFFF (-1) lies inside the window [-256, 256] and 0xFFFE00 (-512) lies below it.
- R4: A request sampled at clock edge N produces its flags, break pulse and interrupt change after edge N+`CMP_CYCLES` (8). The comparator starts at most one comparison every `CMP_CYCLES` clocks. A request that arrives while the same channel's earlier request is being granted is kept and served next.
- R5: When both channels request in the same cycle, channel 0 is served first. Channel 1's result follows `CMP_CYCLES` clocks later, and no request is lost.
- R6: Flags are sticky. Writing 1 to a clear bit resets only that flag, and writing 0 changes nothing.
- R7: If a clear and a new event hit the same flag on the same edge, the flag stays set.
- R8: The global event output (status bit 4) is 1 while any flag is set, and it returns to 0 only after all four flags are clear.
- R9: The interrupt output equals the global event ANDed with the interrupt enable (control bit 8). A change of the enable reaches the interrupt one clock later.
- R10: Each comparison result pulses the break lines for exactly one clock. The pulse pattern is the above-select field when the sample is above the window, ORed with the below-select field when it is below.
- R11: Requests from a channel whose enable bit (control bit 0 or 1) is 0 are ignored.
- R12: Control and limit registers read back what was written. The clear register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 2 | Per-channel new-sample request, one clock |
| sample_i | input | 48 | Channel samples, channel c in bits [24c+23:24c] |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Registered read data, one clock after the address |
| mon_evt_o | output | 1 | Global event, OR of all flags |
| irq_o | output | 1 | Interrupt request |
| brk_o | output | 2 | Break pulses |

## Verification
A wrong arbiter or comparator state shows up at the break lines. It appears as a pulse one or more clocks away from the expected edge N+8 or N+16, or as a missing second pulse when two requests collide. The bench checks pulse timing at the edge before, at and after each expected result, so an off-by-one counter is caught within one comparison. A corrupted flag or a faulty clear shows up in the status read and on the global event within one clock of the offending write.

// File: rtl/wm_pkg.sv
package wm_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned REG_DW = 32;
  typedef logic [REG_AW-1:0] reg_addr_t;

  localparam reg_addr_t ADR_CTRL   = 3'd0;
  localparam reg_addr_t ADR_UPPER  = 3'd1;
  localparam reg_addr_t ADR_LOWER  = 3'd2;
  localparam reg_addr_t ADR_STATUS = 3'd3;
  localparam reg_addr_t ADR_CLEAR  = 3'd4;

  localparam int unsigned CTRL_IRQ_BIT  = 8;
  localparam int unsigned CTRL_HSEL_LSB = 16;
  localparam int unsigned CTRL_LSEL_LSB = 24;
endpackage

// File: rtl/wm_regs.sv
module wm_regs
  import wm_pkg::*;
#(
  parameter int unsigned NCH  = 2,
  parameter int unsigned DW   = 24,
  parameter int unsigned NBRK = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_addr_t         wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  input  reg_addr_t         rd_addr,
  input  logic [NCH-1:0]    hi_flags,
  input  logic [NCH-1:0]    lo_flags,
  input  logic              evt,
  output logic [NCH-1:0]    chan_en,
  output logic              irq_en,
  output logic [NBRK-1:0]   hi_sel,
  output logic [NBRK-1:0]   lo_sel,
  output logic [DW-1:0]     upper,
  output logic [DW-1:0]     lower,
  output logic [NCH-1:0]    clr_hi,
  output logic [NCH-1:0]    clr_lo,
  output logic [REG_DW-1:0] rd_data
);
  logic              clr_hit;
  logic [REG_DW-1:0] rd_next;
  logic              wr_unused;

  assign wr_unused = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_en <= '0;
      irq_en  <= 1'b0;
      hi_sel  <= '0;
      lo_sel  <= '0;
      upper   <= '0;
      lower   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: begin
          chan_en <= wr_data[NCH-1:0];
          irq_en  <= wr_data[CTRL_IRQ_BIT];
          hi_sel  <= wr_data[CTRL_HSEL_LSB +: NBRK];
          lo_sel  <= wr_data[CTRL_LSEL_LSB +: NBRK];
        end
        ADR_UPPER: upper <= wr_data[DW-1:0];
        ADR_LOWER: lower <= wr_data[DW-1:0];
        default: ;
      endcase
    end
  end

  // clear strobes act on the same edge as the write
  assign clr_hit = wr_en && (wr_addr == ADR_CLEAR);
  assign clr_hi  = clr_hit ? wr_data[NCH-1:0]   : '0;
  assign clr_lo  = clr_hit ? wr_data[NCH +: NCH] : '0;

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      ADR_CTRL: begin
        rd_next[NCH-1:0]                 = chan_en;
        rd_next[CTRL_IRQ_BIT]            = irq_en;
        rd_next[CTRL_HSEL_LSB +: NBRK]   = hi_sel;
        rd_next[CTRL_LSEL_LSB +: NBRK]   = lo_sel;
      end
      ADR_UPPER: rd_next[DW-1:0] = upper;
      ADR_LOWER: rd_next[DW-1:0] = lower;
      ADR_STATUS: begin
        rd_next[NCH-1:0]   = hi_flags;
        rd_next[NCH +: NCH] = lo_flags;
        rd_next[2*NCH]     = evt;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/wm_pending.sv
module wm_pending #(
  parameter int unsigned NCH  = 2,
  parameter int unsigned DW   = 24,
  parameter int unsigned CH_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    req,
  input  logic [NCH*DW-1:0] data,
  input  logic [NCH-1:0]    chan_en,
  input  logic              take,
  input  logic [CH_W-1:0]   take_ch,
  output logic              pick_vld,
  output logic [CH_W-1:0]   pick_ch,
  output logic [DW-1:0]     pick_data
);
  logic [NCH-1:0]    pend;
  logic [NCH*DW-1:0] pflat;

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    logic          p_q;
    logic [DW-1:0] d_q;

    // a new request outranks the grant that empties the slot
    always_ff @(posedge clk) begin
      if (rst) begin
        p_q <= 1'b0;
        d_q <= '0;
      end else if (req[g] && chan_en[g]) begin
        p_q <= 1'b1;
        d_q <= data[g*DW +: DW];
      end else if (take && (take_ch == CH_W'(g))) begin
        p_q <= 1'b0;
      end
    end

    assign pend[g]            = p_q;
    assign pflat[g*DW +: DW]  = d_q;
  end

  // fixed priority: lowest channel index wins
  always_comb begin
    pick_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) pick_ch = CH_W'(i);
    end
  end

  assign pick_vld  = |pend;
  assign pick_data = pflat[pick_ch*DW +: DW];
endmodule

// File: rtl/wm_compare.sv
module wm_compare #(
  parameter int unsigned DW         = 24,
  parameter int unsigned CH_W       = 1,
  parameter int unsigned CMP_CYCLES = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pick_vld,
  input  logic [CH_W-1:0] pick_ch,
  input  logic [DW-1:0]   pick_data,
  input  logic [DW-1:0]   upper,
  input  logic [DW-1:0]   lower,
  output logic            take,
  output logic            done,
  output logic [CH_W-1:0] done_ch,
  output logic            hi_hit,
  output logic            lo_hit
);
  // CMP_CYCLES must be at least 2
  localparam int unsigned CNT_W = (CMP_CYCLES > 2) ? $clog2(CMP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CMP_CYCLES - 2);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    d_q;

  assign take = !busy && pick_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      done_ch <= '0;
      d_q     <= '0;
    end else if (!busy) begin
      cnt <= '0;
      if (pick_vld) begin
        busy    <= 1'b1;
        done_ch <= pick_ch;
        d_q     <= pick_data;
      end
    end else if (cnt == LAST) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done   = busy && (cnt == LAST);
  assign hi_hit = $signed(d_q) > $signed(upper);
  assign lo_hit = $signed(d_q) < $signed(lower);
endmodule

// File: rtl/wm_events.sv
module wm_events #(
  parameter int unsigned NCH  = 2,
  parameter int unsigned NBRK = 2,
  parameter int unsigned CH_W = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            done,
  input  logic [CH_W-1:0] done_ch,
  input  logic            hi_hit,
  input  logic            lo_hit,
  input  logic [NCH-1:0]  clr_hi,
  input  logic [NCH-1:0]  clr_lo,
  input  logic            irq_en,
  input  logic [NBRK-1:0] hi_sel,
  input  logic [NBRK-1:0] lo_sel,
  output logic [NCH-1:0]  hi_flags,
  output logic [NCH-1:0]  lo_flags,
  output logic            evt_o,
  output logic            irq_o,
  output logic [NBRK-1:0] brk_o
);
  logic [NCH-1:0] set_hi, set_lo, hi_next, lo_next;
  logic           any_next;

  always_comb begin
    set_hi = '0;
    set_lo = '0;
    if (done) begin
      for (int i = 0; i < NCH; i++) begin
        if (done_ch == CH_W'(i)) begin
          set_hi[i] = hi_hit;
          set_lo[i] = lo_hit;
        end
      end
    end
  end

  // set outranks clear
  assign hi_next  = (hi_flags & ~clr_hi) | set_hi;
  assign lo_next  = (lo_flags & ~clr_lo) | set_lo;
  assign any_next = |{hi_next, lo_next};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_flags <= '0;
      lo_flags <= '0;
      evt_o    <= 1'b0;
      irq_o    <= 1'b0;
      brk_o    <= '0;
    end else begin
      hi_flags <= hi_next;
      lo_flags <= lo_next;
      evt_o    <= any_next;
      irq_o    <= irq_en && any_next;
      brk_o    <= done ? ((hi_hit ? hi_sel : '0) | (lo_hit ? lo_sel : '0)) : '0;
    end
  end
endmodule

// File: rtl/dual_window_monitor.sv
module dual_window_monitor
  import wm_pkg::*;
#(
  parameter int unsigned NCH        = 2,
  parameter int unsigned DW         = 24,
  parameter int unsigned NBRK       = 2,
  parameter int unsigned CMP_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    req_i,
  input  logic [NCH*DW-1:0] sample_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [REG_DW-1:0] wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [REG_DW-1:0] rd_data_o,
  output logic              mon_evt_o,
  output logic              irq_o,
  output logic [NBRK-1:0]   brk_o
);
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0]  chan_en, clr_hi, clr_lo, hi_flags, lo_flags;
  logic            irq_en;
  logic [NBRK-1:0] hi_sel, lo_sel;
  logic [DW-1:0]   upper, lower, pick_data;
  logic            pick_vld, take, cmp_done, hi_hit, lo_hit;
  logic [CH_W-1:0] pick_ch, done_ch;

  wm_regs #(.NCH(NCH), .DW(DW), .NBRK(NBRK)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i), .rd_addr(rd_addr_i),
    .hi_flags(hi_flags), .lo_flags(lo_flags), .evt(mon_evt_o),
    .chan_en(chan_en), .irq_en(irq_en), .hi_sel(hi_sel), .lo_sel(lo_sel),
    .upper(upper), .lower(lower), .clr_hi(clr_hi), .clr_lo(clr_lo),
    .rd_data(rd_data_o)
  );

  wm_pending #(.NCH(NCH), .DW(DW), .CH_W(CH_W)) u_pend (
    .clk(clk), .rst(rst), .req(req_i), .data(sample_i), .chan_en(chan_en),
    .take(take), .take_ch(pick_ch),
    .pick_vld(pick_vld), .pick_ch(pick_ch), .pick_data(pick_data)
  );

  wm_compare #(.DW(DW), .CH_W(CH_W), .CMP_CYCLES(CMP_CYCLES)) u_cmp (
    .clk(clk), .rst(rst), .pick_vld(pick_vld), .pick_ch(pick_ch), .pick_data(pick_data),
    .upper(upper), .lower(lower), .take(take), .done(cmp_done), .done_ch(done_ch),
    .hi_hit(hi_hit), .lo_hit(lo_hit)
  );

  wm_events #(.NCH(NCH), .NBRK(NBRK), .CH_W(CH_W)) u_evt (
    .clk(clk), .rst(rst), .done(cmp_done), .done_ch(done_ch),
    .hi_hit(hi_hit), .lo_hit(lo_hit), .clr_hi(clr_hi), .clr_lo(clr_lo),
    .irq_en(irq_en), .hi_sel(hi_sel), .lo_sel(lo_sel),
    .hi_flags(hi_flags), .lo_flags(lo_flags),
    .evt_o(mon_evt_o), .irq_o(irq_o), .brk_o(brk_o)
  );
endmodule

// File: rtl/wm_checker.sv
module wm_checker #(
  parameter int unsigned NCH  = 2,
  parameter int unsigned NBRK = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [NCH-1:0]  hi_flags,
  input logic [NCH-1:0]  lo_flags,
  input logic [NCH-1:0]  clr_hi,
  input logic [NCH-1:0]  clr_lo,
  input logic            done,
  input logic            irq_en,
  input logic            irq_o,
  input logic [NBRK-1:0] brk_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assert_hi_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      (hi_flags[i] && !clr_hi[i]) |=> hi_flags[i]);
    assert_lo_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      (lo_flags[i] && !clr_lo[i]) |=> lo_flags[i]);
    assert_hi_from_result_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(hi_flags[i]) |-> $past(done));
    assert_lo_from_result_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(lo_flags[i]) |-> $past(done));
  end

  for (genvar b = 0; b < NBRK; b++) begin : g_brk
    assert_brk_one_clock_R10: assert property (@(posedge clk) disable iff (rst)
      brk_o[b] |=> !brk_o[b]);
  end

  assert_brk_after_result_R10: assert property (@(posedge clk) disable iff (rst)
    (|brk_o) |-> $past(done));

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(irq_en) |-> !irq_o);
endmodule

bind dual_window_monitor wm_checker #(.NCH(NCH), .NBRK(NBRK)) u_chk (
  .clk(clk), .rst(rst), .hi_flags(hi_flags), .lo_flags(lo_flags),
  .clr_hi(clr_hi), .clr_lo(clr_lo), .done(cmp_done), .irq_en(irq_en),
  .irq_o(irq_o), .brk_o(brk_o)
);

// File: tb/dual_window_monitor_tb.sv
module dual_window_monitor_tb;
  localparam logic [2:0] A_CTRL = 3'd0, A_UP = 3'd1, A_LO = 3'd2, A_ST = 3'd3, A_CLR = 3'd4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  req_i = '0;
  logic [47:0] sample_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        mon_evt_o, irq_o;
  logic [1:0]  brk_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dual_window_monitor u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .sample_i(sample_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .mon_evt_o(mon_evt_o),
    .irq_o(irq_o), .brk_o(brk_o)
  );

  function automatic logic [31:0] ctrl(input logic [1:0] en, input logic ie,
                                       input logic [1:0] hs, input logic [1:0] ls);
    return {6'd0, ls, 6'd0, hs, 7'd0, ie, 6'd0, en};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr_i = a;
    @(negedge clk);
    d = rd_data_o;
  endtask

  // returns just after the sampling edge (k = 0)
  task automatic pulse(input logic [1:0] m, input logic [23:0] d0, input logic [23:0] d1);
    req_i = m; sample_i = {d1, d0};
    @(negedge clk);
    req_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 brk", {30'd0, brk_o}, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 evt", {31'd0, mon_evt_o}, 0);
    rd(A_ST, v);   chk("R1 status", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_UP, v);   chk("R1 upper", v, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(A_UP, 32'h000100);
    wr(A_LO, 32'hFFFF00);
    wr(A_CTRL, ctrl(2'b11, 1'b0, 2'b01, 2'b10));
    rd(A_UP, v);   chk("R12 upper", v, 32'h000100);
    rd(A_LO, v);   chk("R12 lower", v, 32'hFFFF00);
    rd(A_CTRL, v); chk("R12 ctrl", v, ctrl(2'b11, 1'b0, 2'b01, 2'b10));
    rd(A_CLR, v);  chk("R12 clear reads 0", v, 0);
  endtask

  task automatic t_latency();
    logic [31:0] v;
    pulse(2'b01, 24'h000101, 24'h0);
    wait_n(7);
    chk("R4 no break before N+8", {30'd0, brk_o}, 0);
    chk("R4 no event before N+8", {31'd0, mon_evt_o}, 0);
    wait_n(1);
    chk("R10 above break at N+8", {30'd0, brk_o}, 2'b01);
    chk("R8 event at N+8", {31'd0, mon_evt_o}, 1);
    wait_n(1);
    chk("R10 break one clock", {30'd0, brk_o}, 0);
    rd(A_ST, v); chk("R2 above flag ch0", v, 32'h11);
    wr(A_CLR, 32'hF);
    rd(A_ST, v); chk("R6 clear all", v, 0);
  endtask

  task automatic t_equal();
    logic [31:0] v;
    pulse(2'b10, 24'h0, 24'h000100);
    wait_n(12);
    rd(A_ST, v); chk("R2 equal upper no flag", v, 0);
    pulse(2'b01, 24'hFFFF00, 24'h0);
    wait_n(12);
    rd(A_ST, v); chk("R2 equal lower no flag", v, 0);
  endtask

  task automatic t_signed();
    logic [31:0] v;
    pulse(2'b10, 24'h0, 24'hFFFFFF);
    wait_n(12);
    rd(A_ST, v); chk("R3 minus one inside", v, 0);
    pulse(2'b10, 24'h0, 24'hFFFE00);
    wait_n(8);
    chk("R3 below break", {30'd0, brk_o}, 2'b10);
    rd(A_ST, v); chk("R3 below flag ch1", v, 32'h18);
    pulse(2'b01, 24'h7FFFFF, 24'h0);
    wait_n(12);
    rd(A_ST, v); chk("R3 max positive above", v, 32'h19);
    wr(A_CLR, 32'hF);
  endtask

  task automatic t_pair();
    logic [31:0] v;
    pulse(2'b11, 24'h000200, 24'hFFF000);
    wait_n(8);
    chk("R5 ch0 first", {30'd0, brk_o}, 2'b01);
    wait_n(7);
    chk("R5 gap before ch1", {30'd0, brk_o}, 0);
    wait_n(1);
    chk("R5 ch1 at N+16", {30'd0, brk_o}, 2'b10);
    rd(A_ST, v); chk("R5 both flags", v, 32'h19);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(A_CLR, 32'h0);
    rd(A_ST, v); chk("R6 write zero no effect", v, 32'h19);
    wr(A_CLR, 32'h1);
    chk("R8 event held by other flag", {31'd0, mon_evt_o}, 1);
    rd(A_ST, v); chk("R6 clear one flag", v, 32'h18);
    wr(A_CLR, 32'h8);
    chk("R8 event drops when all clear", {31'd0, mon_evt_o}, 0);
    rd(A_ST, v); chk("R6 all clear", v, 0);
  endtask

  task automatic t_back_to_back();
    logic [31:0] v;
    req_i = 2'b01; sample_i = {24'h0, 24'hFFF000};
    @(negedge clk);
    sample_i = {24'h0, 24'h000300};
    @(negedge clk);
    req_i = '0;
    wait_n(7);
    chk("R4 first result N+8", {30'd0, brk_o}, 2'b10);
    wait_n(7);
    chk("R4 comparator busy", {30'd0, brk_o}, 0);
    wait_n(1);
    chk("R4 second result N+16", {30'd0, brk_o}, 2'b01);
    rd(A_ST, v); chk("R4 both kept", v, 32'h15);
    wr(A_CLR, 32'hF);
  endtask

  task automatic t_route();
    logic [31:0] v;
    wr(A_CTRL, ctrl(2'b11, 1'b0, 2'b11, 2'b00));
    pulse(2'b01, 24'h000400, 24'h0);
    wait_n(8);
    chk("R10 above to both lines", {30'd0, brk_o}, 2'b11);
    pulse(2'b10, 24'h0, 24'hFFF000);
    wait_n(8);
    chk("R10 below routed nowhere", {30'd0, brk_o}, 0);
    rd(A_ST, v); chk("R10 flags still set", v, 32'h19);
    wr(A_CLR, 32'hF);
    wr(A_CTRL, ctrl(2'b11, 1'b0, 2'b01, 2'b10));
  endtask

  task automatic t_irq();
    wr(A_CTRL, ctrl(2'b11, 1'b1, 2'b01, 2'b10));
    chk("R9 no irq without flags", {31'd0, irq_o}, 0);
    pulse(2'b01, 24'h000500, 24'h0);
    wait_n(7);
    chk("R9 irq low before result", {31'd0, irq_o}, 0);
    wait_n(1);
    chk("R9 irq with flag", {31'd0, irq_o}, 1);
    wr(A_CLR, 32'h1);
    chk("R9 irq drops on clear", {31'd0, irq_o}, 0);
    pulse(2'b01, 24'h000500, 24'h0);
    wait_n(9);
    wr(A_CTRL, ctrl(2'b11, 1'b0, 2'b01, 2'b10));
    wait_n(1);
    chk("R9 irq off when disabled", {31'd0, irq_o}, 0);
    chk("R9 event stays", {31'd0, mon_evt_o}, 1);
    wr(A_CLR, 32'hF);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    pulse(2'b01, 24'h000600, 24'h0);
    wait_n(9);
    pulse(2'b01, 24'h000600, 24'h0);
    wait_n(7);
    wr(A_CLR, 32'h1);
    rd(A_ST, v); chk("R7 set beats clear", v, 32'h11);
    wr(A_CLR, 32'h1);
    rd(A_ST, v); chk("R7 later clear works", v, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr(A_CTRL, ctrl(2'b01, 1'b0, 2'b01, 2'b10));
    pulse(2'b10, 24'h0, 24'h000700);
    wait_n(12);
    rd(A_ST, v); chk("R11 disabled channel ignored", v, 0);
    chk("R11 no event", {31'd0, mon_evt_o}, 0);
    pulse(2'b01, 24'h000700, 24'h0);
    wait_n(8);
    chk("R11 enabled channel served", {30'd0, brk_o}, 2'b01);
    wr(A_CLR, 32'hF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_latency();
    t_equal();
    t_signed();
    t_pair();
    t_w1c();
    t_back_to_back();
    t_route();
    t_irq();
    t_set_wins();
    t_disabled();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule